// File: doc/BRIEF.md
# Fault-Tolerant Pipelined Byte Substitution Unit

This block performs the AES byte substitution on one byte per clock. The substitution is built from gates and split across four register-separated stages: a squaring/multiplying chain that raises the byte to the 254th power in GF(2^8), which is its multiplicative inverse and maps zero to zero, followed by the fixed affine transform. A source offers a byte with a valid flag and the substituted byte comes out a fixed number of cycles later with its own valid flag.

Every stage is evaluated by two independent copies of its logic. The two results are compared before the stage register. When any stage disagrees, that stage's error flag rises, every stage register freezes, and the input is refused. Because each stage's input register does not move, the stalled stage re-evaluates the same operands on the next cycle. The pipeline advances again only once both copies agree, so a transient upset of any length costs cycles but does not corrupt data. Per-stage, per-copy XOR masks allow faults to be injected for test.

Top module: `sbox_ft`

## Requirements
- R1: `outByte` equals the substitution of the accepted byte. The substitution is the inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 treated as 0, followed by the affine transform `b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63`. For example, 0x00 gives 0x63, 0x01 gives 0x7C and 0x53 gives 0xED.
- R2: With no fault, a byte accepted on clock edge t produces `outValid` high after edge t+3, and `outValid` stays low after edges t, t+1 and t+2.
- R3: `stageErr[s]` is 1 exactly when the two copies of stage s disagree. The fault mask for stage s occupies bits [8s+7:8s] of `injectA` (first copy) and `injectB` (second copy), and is XORed into the low byte of that copy's stage result.
- R4: `inReady` is low in every cycle in which any `stageErr` bit is set, and high in every other cycle.
- R5: In the cycle after a cycle with any `stageErr` bit set, `outValid` is low and `outByte` keeps its previous value.
- R6: Transient faults of 1 to 5 cycles, in any stage and in either or both copies (with differing masks), yield the same output byte sequence as a fault-free run over the same inputs.
- R7: Each accepted byte produces exactly one cycle of `outValid`. A back-to-back stream of 256 bytes yields 256 outputs in input order.
- R8: After reset with no injected fault, `outValid` is 0, `inReady` is 1 and `stageErr` is 0.
- R9: A byte offered with `inValid` while `inReady` is low is not taken and never reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inByte | input | 8 | Byte to substitute |
| inValid | input | 1 | `inByte` is offered this cycle |
| inReady | output | 1 | Byte is taken at the next edge when `inValid` is also high |
| outByte | output | 8 | Substituted byte |
| outValid | output | 1 | `outByte` holds a new result this cycle |
| injectA | input | 32 | Per-stage XOR fault masks for the first copy, 8 bits per stage |
| injectB | input | 32 | Per-stage XOR fault masks for the second copy, 8 bits per stage |
| stageErr | output | 4 | Per-stage disagreement flags |

## Verification
The bench builds the block with its defaults: four stages over an 8-bit byte, giving 32-bit injection vectors. This is small enough to stream all 256 input bytes in a fault-free pass and again in a faulted pass, and to compare both against a table the bench derives by brute-force inversion. In the faulted pass the injection walks through every stage, through each copy alone and through both copies with differing masks, with durations of one to five cycles while the pipeline is full. A further scenario offers a decoy byte during a stall to confirm that it is refused.

// File: rtl/sbox_ft_pkg.sv
package sbox_ft_pkg;

  localparam int BYTE_W     = 8;
  localparam int NUM_STAGES = 4;
  localparam int INJ_W      = NUM_STAGES * BYTE_W;
  localparam int SQ_MAX     = 4;

  localparam logic [BYTE_W-1:0] REDUCE_LOW = 8'h1B;
  localparam logic [BYTE_W-1:0] AFFINE_ADD = 8'h63;

  // Strobes from the hold control to the datapath
  typedef struct packed {
    logic [NUM_STAGES-1:0] stageEn;
    logic                  inReady;
    logic                  lastDrain;
  } ctrl_t;

  // Width of the operand bundle entering each stage
  function automatic int stageInW(input int s);
    case (s)
      0:       return BYTE_W;
      1:       return 2 * BYTE_W;
      2:       return 3 * BYTE_W;
      default: return 2 * BYTE_W;
    endcase
  endfunction

  function automatic int stageOutW(input int s);
    return (s == NUM_STAGES - 1) ? BYTE_W : stageInW(s + 1);
  endfunction

  // Field multiply, shift-and-add with modular reduction
  function automatic logic [BYTE_W-1:0] gfMul(input logic [BYTE_W-1:0] a,
                                              input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[BYTE_W-1] ? ({sh[BYTE_W-2:0], 1'b0} ^ REDUCE_LOW)
                        : {sh[BYTE_W-2:0], 1'b0};
    end
    return acc;
  endfunction

  // Repeated squaring: returns a^(2^n), n up to SQ_MAX
  function automatic logic [BYTE_W-1:0] gfSqN(input logic [BYTE_W-1:0] a,
                                              input int n);
    logic [BYTE_W-1:0] r;
    r = a;
    for (int i = 0; i < SQ_MAX; i++) begin
      if (i < n) r = gfMul(r, r);
    end
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] affineMap(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) begin
      r[i] = b[i] ^ b[(i + 4) % BYTE_W] ^ b[(i + 5) % BYTE_W]
           ^ b[(i + 6) % BYTE_W] ^ b[(i + 7) % BYTE_W] ^ AFFINE_ADD[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/sbox_ft_copy.sv
module sbox_ft_copy
  import sbox_ft_pkg::*;
#(
  parameter  int STAGE = 0,
  localparam int IN_W  = stageInW(STAGE),
  localparam int OUT_W = stageOutW(STAGE)
) (
  input  logic [IN_W-1:0]   dIn,
  input  logic [BYTE_W-1:0] inj,
  output logic [OUT_W-1:0]  dOut
);

  logic [OUT_W-1:0] core;
  logic [OUT_W-1:0] injWide;

  always_comb begin
    injWide = '0;
    injWide[BYTE_W-1:0] = inj;
  end

  // Exponent chain for x^254: x^2, x^3 -> x^12, x^15 -> x^252 -> x^254
  generate
    case (STAGE)
      0: begin : gSquare
        logic [BYTE_W-1:0] x2;
        assign x2   = gfSqN(dIn, 1);
        assign core = {x2, gfMul(x2, dIn)};
      end
      1: begin : gPow15
        logic [BYTE_W-1:0] x2, x3, p12;
        assign x2   = dIn[2*BYTE_W-1:BYTE_W];
        assign x3   = dIn[BYTE_W-1:0];
        assign p12  = gfSqN(x3, 2);
        assign core = {x2, p12, gfMul(p12, x3)};
      end
      2: begin : gPow252
        logic [BYTE_W-1:0] x2, p12, p15;
        assign x2   = dIn[3*BYTE_W-1:2*BYTE_W];
        assign p12  = dIn[2*BYTE_W-1:BYTE_W];
        assign p15  = dIn[BYTE_W-1:0];
        assign core = {x2, gfMul(gfSqN(p15, 4), p12)};
      end
      default: begin : gFinish
        logic [BYTE_W-1:0] inv;
        assign inv  = gfMul(dIn[BYTE_W-1:0], dIn[2*BYTE_W-1:BYTE_W]);
        assign core = affineMap(inv);
      end
    endcase
  endgenerate

  assign dOut = core ^ injWide;

endmodule

// File: rtl/sbox_ft_datapath.sv
module sbox_ft_datapath
  import sbox_ft_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BYTE_W-1:0]     inByte,
  input  logic                  inValid,
  input  ctrl_t                 ctl,
  input  logic [INJ_W-1:0]      injectA,
  input  logic [INJ_W-1:0]      injectB,
  output logic [NUM_STAGES-1:0] errVec,
  output logic [BYTE_W-1:0]     outByte,
  output logic                  outValid
);

  for (genvar s = 0; s < NUM_STAGES; s++) begin : gStage
    localparam int  IW   = stageInW(s);
    localparam int  OW   = stageOutW(s);
    localparam bit  LAST = (s == NUM_STAGES - 1);

    logic [IW-1:0] stIn;
    logic [OW-1:0] resA, resB, stReg;
    logic          vIn, stVld;

    if (s == 0) begin : gHead
      assign stIn = inByte;
      assign vIn  = inValid & ctl.inReady;
    end else begin : gBody
      assign stIn = gStage[s-1].stReg;
      assign vIn  = gStage[s-1].stVld;
    end

    sbox_ft_copy #(.STAGE(s)) uCopyA (
      .dIn (stIn),
      .inj (injectA[s*BYTE_W +: BYTE_W]),
      .dOut(resA)
    );

    sbox_ft_copy #(.STAGE(s)) uCopyB (
      .dIn (stIn),
      .inj (injectB[s*BYTE_W +: BYTE_W]),
      .dOut(resB)
    );

    assign errVec[s] = (resA != resB);

    // Voter register: only ever loads an agreed result
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stReg <= '0;
        stVld <= 1'b0;
      end else if (ctl.stageEn[s]) begin
        stReg <= resA;
        stVld <= vIn;
      end else if (LAST && ctl.lastDrain) begin
        stVld <= 1'b0;
      end
    end
  end

  assign outByte  = gStage[NUM_STAGES-1].stReg;
  assign outValid = gStage[NUM_STAGES-1].stVld;

endmodule

// File: rtl/sbox_ft_ctrl.sv
module sbox_ft_ctrl
  import sbox_ft_pkg::*;
(
  input  logic [NUM_STAGES-1:0] errVec,
  output ctrl_t                 ctl
);

  logic hold;

  assign hold = |errVec;

  always_comb begin
    ctl.stageEn   = {NUM_STAGES{~hold}};
    ctl.inReady   = ~hold;
    ctl.lastDrain = hold;
  end

endmodule

// File: rtl/sbox_ft.sv
module sbox_ft
  import sbox_ft_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BYTE_W-1:0]     inByte,
  input  logic                  inValid,
  output logic                  inReady,
  output logic [BYTE_W-1:0]     outByte,
  output logic                  outValid,
  input  logic [INJ_W-1:0]      injectA,
  input  logic [INJ_W-1:0]      injectB,
  output logic [NUM_STAGES-1:0] stageErr
);

  ctrl_t ctl;

  sbox_ft_ctrl uCtrl (
    .errVec(stageErr),
    .ctl   (ctl)
  );

  sbox_ft_datapath uDp (
    .clk     (clk),
    .rstN    (rstN),
    .inByte  (inByte),
    .inValid (inValid),
    .ctl     (ctl),
    .injectA (injectA),
    .injectB (injectB),
    .errVec  (stageErr),
    .outByte (outByte),
    .outValid(outValid)
  );

  assign inReady = ctl.inReady;

endmodule

// File: rtl/sbox_ft_chk.sv
module sbox_ft_chk
  import sbox_ft_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  inReady,
  input logic [BYTE_W-1:0]     outByte,
  input logic                  outValid,
  input logic [INJ_W-1:0]      injectA,
  input logic [INJ_W-1:0]      injectB,
  input logic [NUM_STAGES-1:0] stageErr
);

  // R3: each flag follows disagreement between the copies' fault masks
  for (genvar s = 0; s < NUM_STAGES; s++) begin : gErrChk
    a_r3_err_tracks_copies: assert property (@(posedge clk) disable iff (!rstN)
      stageErr[s] == (injectA[s*BYTE_W +: BYTE_W] != injectB[s*BYTE_W +: BYTE_W]));
  end

  a_r4_stall_drops_ready: assert property (@(posedge clk) disable iff (!rstN)
    (|stageErr) |-> !inReady);

  a_r4_ready_when_agree: assert property (@(posedge clk) disable iff (!rstN)
    !(|stageErr) |-> inReady);

  a_r5_hold_freezes_output: assert property (@(posedge clk) disable iff (!rstN)
    (|stageErr) |=> (!outValid && $stable(outByte)));

endmodule

bind sbox_ft sbox_ft_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inReady (inReady),
  .outByte (outByte),
  .outValid(outValid),
  .injectA (injectA),
  .injectB (injectB),
  .stageErr(stageErr)
);

// File: tb/sbox_ft_tb.sv
module sbox_ft_tb;
  import sbox_ft_pkg::*;

  logic                  clk = 1'b0;
  logic                  rstN;
  logic [BYTE_W-1:0]     inByte;
  logic                  inValid;
  logic                  inReady;
  logic [BYTE_W-1:0]     outByte;
  logic                  outValid;
  logic [INJ_W-1:0]      injectA;
  logic [INJ_W-1:0]      injectB;
  logic [NUM_STAGES-1:0] stageErr;

  int checks = 0;
  int fails  = 0;
  int outCnt = 0;
  logic [7:0] refTab [256];
  logic [7:0] outLog [1024];

  always #10 clk = ~clk;

  sbox_ft u_dut (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid),
    .inReady(inReady), .outByte(outByte), .outValid(outValid),
    .injectA(injectA), .injectB(injectB), .stageErr(stageErr)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Reference arithmetic: carry-less product then polynomial reduction
  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int k = 14; k >= 8; k--) if (p[k]) p = p ^ (15'h11B << (k - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] refSub(input logic [7:0] x);
    logic [7:0] inv;
    inv = 8'h00;
    if (x != 8'h00)
      for (int y = 1; y < 256; y++) if (refMul(x, 8'(y)) == 8'h01) inv = 8'(y);
    return inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
  endfunction

  task automatic present(input logic [7:0] b, input logic v,
                         input logic [INJ_W-1:0] ia, input logic [INJ_W-1:0] ib);
    @(negedge clk);
    inByte  = b;
    inValid = v;
    injectA = ia;
    injectB = ib;
    #1;
  endtask

  task automatic drain();
    repeat (10) @(negedge clk);
    #3;
  endtask

  // Output monitor, also checks the hold behaviour (R5)
  initial begin
    logic       prevErr;
    logic [7:0] prevOut;
    prevErr = 1'b0;
    prevOut = 8'h00;
    forever begin
      @(negedge clk);
      #2;
      if (rstN) begin
        if (prevErr) begin
          check(!outValid, "R5 valid low after stall", 32'(outValid), 32'h0);
          check(outByte == prevOut, "R5 byte held after stall", 32'(outByte), 32'(prevOut));
        end
        if (outValid && outCnt < 1024) begin
          outLog[outCnt] = outByte;
          outCnt++;
        end
      end
      prevErr = |stageErr;
      prevOut = outByte;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    int base;
    logic [INJ_W-1:0] ia, ib;

    rstN = 1'b0; inValid = 1'b0; inByte = '0; injectA = '0; injectB = '0;
    for (int i = 0; i < 256; i++) refTab[i] = refSub(8'(i));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    check(!outValid, "R8 outValid after reset", 32'(outValid), 32'h0);
    check(inReady, "R8 inReady after reset", 32'(inReady), 32'h1);
    check(stageErr == '0, "R8 stageErr after reset", 32'(stageErr), 32'h0);

    // R2 latency with a single byte
    present(8'h53, 1'b1, '0, '0);
    check(inReady, "R2 offer accepted", 32'(inReady), 32'h1);
    present(8'h00, 1'b0, '0, '0);
    #1;
    check(!outValid, "R2 no valid after edge t", 32'(outValid), 32'h0);
    for (int k = 1; k < 3; k++) begin
      @(negedge clk); #2;
      check(!outValid, "R2 no valid before edge t+3", 32'(outValid), 32'h0);
    end
    @(negedge clk); #2;
    check(outValid, "R2 valid after edge t+3", 32'(outValid), 32'h1);
    check(outByte == 8'hED, "R1 byte 0x53", 32'(outByte), 32'hED);
    drain();

    // R1 / R7 fault-free exhaustive stream
    base = outCnt;
    for (int i = 0; i < 256; i++) begin
      present(8'(i), 1'b1, '0, '0);
      check(inReady, "R7 ready during clean stream", 32'(inReady), 32'h1);
    end
    present(8'h00, 1'b0, '0, '0);
    drain();
    check(outCnt - base == 256, "R7 output count clean", 32'(outCnt - base), 32'd256);
    check(outLog[base] == 8'h63, "R1 zero maps to 0x63", 32'(outLog[base]), 32'h63);
    for (int i = 0; i < 256; i++)
      check(outLog[base + i] == refTab[i], "R1 clean value", 32'(outLog[base + i]), 32'(refTab[i]));

    // R6 / R3 / R4 faulted exhaustive stream
    base = outCnt;
    for (int i = 0; i < 256; i++) begin
      if (i % 3 == 0) begin
        int d, s, mode;
        logic [7:0] mask;
        d    = (i % 5) + 1;
        s    = (i / 3) % NUM_STAGES;
        mode = (i / 12) % 3;
        mask = 8'h01 << (i % 8);
        for (int k = 0; k < d; k++) begin
          ia = '0;
          ib = '0;
          if (mode != 1) ia[s*BYTE_W +: BYTE_W] = mask;
          if (mode == 1) ib[s*BYTE_W +: BYTE_W] = mask;
          if (mode == 2) ib[s*BYTE_W +: BYTE_W] = ~mask;
          present(8'(i), 1'b1, ia, ib);
          check(!inReady, "R4 ready low during fault", 32'(inReady), 32'h0);
          check(stageErr == NUM_STAGES'(1 << s), "R3 flag of faulted stage",
                32'(stageErr), 32'(1 << s));
        end
      end
      present(8'(i), 1'b1, '0, '0);
      check(inReady, "R4 ready high once agreed", 32'(inReady), 32'h1);
      check(stageErr == '0, "R3 no flag without fault", 32'(stageErr), 32'h0);
    end
    present(8'h00, 1'b0, '0, '0);
    drain();
    check(outCnt - base == 256, "R6 output count faulted", 32'(outCnt - base), 32'd256);
    for (int i = 0; i < 256; i++)
      check(outLog[base + i] == refTab[i], "R6 faulted value", 32'(outLog[base + i]), 32'(refTab[i]));

    // R9 decoy offered during a stall
    base = outCnt;
    for (int k = 0; k < 3; k++) begin
      ia = '0;
      ia[2*BYTE_W +: BYTE_W] = 8'h10;
      present(8'h00, 1'b1, ia, '0);
      check(!inReady, "R9 decoy refused", 32'(inReady), 32'h0);
    end
    present(8'h01, 1'b1, '0, '0);
    check(inReady, "R9 real byte taken", 32'(inReady), 32'h1);
    present(8'h00, 1'b0, '0, '0);
    drain();
    check(outCnt - base == 1, "R9 single output", 32'(outCnt - base), 32'h1);
    check(outLog[base] == 8'h7C, "R9 output is real byte", 32'(outLog[base]), 32'h7C);

    summary();
    $finish;
  end

endmodule